// File: doc/BRIEF.md
# SPI Register-Access Transaction Decoder

This block is the SPI target front end of a register-access path. It works in SPI mode 0: data is sampled on rising SCLK and shifted out on falling SCLK, most significant bit first. SCLK, chip select and MOSI are brought into the system clock domain through synchronisers. An edge detector then drives a single state machine. While chip select is low, that machine parses a header of one or two octets and picks one of four transaction kinds:

- a fast command, which pulses a 5-bit strobe;
- a short addressed access;
- a full addressed access;
- a masked read-modify-write.

Register storage sits outside the block. It is reached through a system-clock port with a 12-bit octet address, write data, a write enable and combinational read data. The address is {file[4:0], sub[6:0]}, which gives 32 files of 128 octets each.

The states are ST_HDR0, ST_HDR1, ST_READ, ST_WRITE, ST_AND, ST_OR and ST_SKIP. Every transition below happens when a complete octet is received, except where noted.

- ST_HDR0 goes to ST_HDR1 for a two-octet header. It goes to ST_SKIP for a fast command. For a short access it goes to ST_READ or ST_WRITE.
- ST_HDR1 goes to ST_READ, ST_WRITE or ST_AND.
- ST_AND goes to ST_OR after the last AND-mask octet.
- ST_OR goes to ST_SKIP after the last OR-mask octet.
- Any state returns to ST_HDR0 whenever chip select is high. This transition does not wait for an octet.

Top module: `spi_regxact_decoder`

## Requirements
- R1: After reset, spi_miso, reg_we and cmd_valid are 0.
- R2: A first octet with bit 6 = 0 and bit 0 = 1 is a fast command. cmd_code takes bits 5:1, and cmd_valid pulses for exactly one clock per such header. No register write follows. For example, 0xA5 gives code 0x12.
- R3: A first octet with bit 6 = 0 and bit 0 = 0 is a short access. Bit 7 selects write (1) or read (0), bits 5:1 give the file, and the sub-address starts at 0.
- R4: A first octet with bit 6 = 1 starts a two-octet header. The sub-address is {octet0[0], octet1[7:2]} and octet1[1:0] is the length mode. Mode 00 is a plain access in the direction of bit 7. For example, 0x4A 0xB0 reads file 0x05 from sub-address 0x2C, and 0xCA 0x40 writes file 0x05 from sub-address 0x10.
- R5: Each data octet after the header advances the sub-address by one, modulo 128, within the same file.
- R6: Read data leaves on spi_miso MSB first. Its first bit appears on the first SCLK falling edge after the header's last bit. spi_miso is 0 during the header and while chip select is high.
- R7: A write octet produces one reg_we pulse, and only after all 8 of its bits have arrived. A partial octet at chip-select rise is discarded.
- R8: A write with mode 01, 10 or 11 is a masked update of N = 1, 2 or 4 octets. The target first receives N AND-mask octets and then N OR-mask octets, least significant octet first. Octet k at sub+k becomes (old AND and_k) OR or_k. Any further octets change nothing.
- R9: On a read (bit 7 = 0), the length-mode bits are ignored and a plain read is performed.
- R10: Raising chip select at any point returns the parser to ST_HDR0, so the next transaction's header is decoded afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, asynchronous |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| reg_addr | output | 12 | Octet address {file, sub} |
| reg_wdata | output | 8 | Octet to write |
| reg_we | output | 1 | One-cycle write enable |
| reg_rdata | input | 8 | Octet at reg_addr, combinational |
| cmd_code | output | 5 | Fast-command code |
| cmd_valid | output | 1 | One-cycle fast-command strobe |

## Verification
The hardest situation to reach is a chip-select rise that lands partway through an octet or partway through a two-octet header. Such an abort must drop the partial data and still leave the next header to be parsed cleanly. The bench stops clocking after a chosen number of bits in the final octet and then raises chip select. Next it checks that the storage is unchanged and sends a fast command, whose decoded code shows whether the parser really returned to idle. Masked updates whose sub-address range wraps past octet 127 are reached through directed starting sub-addresses. These are mixed with seeded random transactions of every kind.

// File: rtl/spi_xact_pkg.sv
`timescale 1ns/1ps
package spi_xact_pkg;
    localparam int FILE_W    = 5;
    localparam int SUB_W     = 7;
    localparam int ADDR_W    = FILE_W + SUB_W;
    localparam int OCT_W     = 8;
    localparam int MASK_OCT  = 4;
    localparam int IDX_W     = $clog2(MASK_OCT);

    typedef enum logic [2:0] {
        ST_HDR0,
        ST_HDR1,
        ST_READ,
        ST_WRITE,
        ST_AND,
        ST_OR,
        ST_SKIP
    } xact_state_e;
endpackage

// File: rtl/spi_edge_sync.sv
`timescale 1ns/1ps
module spi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic csn_i,
    input  logic mosi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic csn_s,
    output logic mosi_s
);
    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] RST_VAL = 3'b100;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] synced;
    logic            sclk_d;

    assign raw = {csn_i, mosi_i, sclk_i};

    for (genvar g = 0; g < NSIG; g++) begin : g_sig
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= {STAGES{RST_VAL[g]}};
            else        sh <= {sh[STAGES-2:0], raw[g]};
        end
        assign synced[g] = sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= synced[0];
    end

    assign sclk_rise = synced[0] & ~sclk_d;
    assign sclk_fall = ~synced[0] & sclk_d;
    assign mosi_s    = synced[1];
    assign csn_s     = synced[2];
endmodule

// File: rtl/mask_merge.sv
`timescale 1ns/1ps
module mask_merge #(
    parameter int W = 8
) (
    input  logic [W-1:0] old_i,
    input  logic [W-1:0] and_i,
    input  logic [W-1:0] or_i,
    output logic [W-1:0] merged_o
);
    assign merged_o = (old_i & and_i) | or_i;
endmodule

// File: rtl/spi_regxact_decoder.sv
`timescale 1ns/1ps
module spi_regxact_decoder
    import spi_xact_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [OCT_W-1:0]  reg_wdata,
    output logic              reg_we,
    input  logic [OCT_W-1:0]  reg_rdata,
    output logic [FILE_W-1:0] cmd_code,
    output logic              cmd_valid
);
    logic sclk_rise, sclk_fall, csn_s, mosi_s;

    spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk_i(spi_sclk), .csn_i(spi_csn), .mosi_i(spi_mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .csn_s(csn_s), .mosi_s(mosi_s)
    );

    xact_state_e       st_q, st_d;
    logic [2:0]        bit_q;
    logic [OCT_W-2:0]  sr_q;
    logic [OCT_W-1:0]  byte_w;
    logic              oct_done;
    logic [FILE_W-1:0] file_q;
    logic [SUB_W-1:0]  sub_q;
    logic              dir_q, subhi_q;
    logic [IDX_W-1:0]  idx_q, nmask_q;
    logic [OCT_W-1:0]  and_q [MASK_OCT];
    logic [OCT_W-1:0]  tx_q, wdata_q, merged;
    logic              ld_q, we_q, miso_q, cv_q;
    logic [FILE_W-1:0] cc_q;

    assign byte_w   = {sr_q, mosi_s};
    assign oct_done = sclk_rise & (bit_q == 3'd7) & ~csn_s;

    mask_merge #(.W(OCT_W)) u_merge (
        .old_i(reg_rdata), .and_i(and_q[idx_q]), .or_i(byte_w), .merged_o(merged)
    );

    // next-state decision
    always_comb begin
        st_d = st_q;
        if (csn_s) begin
            st_d = ST_HDR0;
        end else if (oct_done) begin
            unique case (st_q)
                ST_HDR0: begin
                    if (byte_w[6])      st_d = ST_HDR1;
                    else if (byte_w[0]) st_d = ST_SKIP;
                    else                st_d = byte_w[7] ? ST_WRITE : ST_READ;
                end
                ST_HDR1: begin
                    if (!dir_q)                 st_d = ST_READ;
                    else if (byte_w[1:0] == '0) st_d = ST_WRITE;
                    else                        st_d = ST_AND;
                end
                ST_AND:  if (idx_q == nmask_q) st_d = ST_OR;
                ST_OR:   if (idx_q == nmask_q) st_d = ST_SKIP;
                default: st_d = st_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HDR0;
        else        st_q <= st_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0; sr_q <= '0; file_q <= '0; sub_q <= '0;
            dir_q <= 1'b0; subhi_q <= 1'b0; idx_q <= '0; nmask_q <= '0;
            for (int k = 0; k < MASK_OCT; k++) and_q[k] <= '0;
            tx_q <= '0; wdata_q <= '0; ld_q <= 1'b0; we_q <= 1'b0;
            miso_q <= 1'b0; cv_q <= 1'b0; cc_q <= '0;
        end else begin
            cv_q <= 1'b0;
            we_q <= 1'b0;
            ld_q <= 1'b0;
            if (we_q) sub_q <= sub_q + 1'b1;
            if (ld_q) tx_q <= reg_rdata;
            if (csn_s) begin
                bit_q  <= '0;
                miso_q <= 1'b0;
            end else begin
                if (sclk_rise) begin
                    sr_q  <= byte_w[OCT_W-2:0];
                    bit_q <= bit_q + 3'd1;
                end
                if (sclk_fall) begin
                    if (st_q == ST_READ) begin
                        miso_q <= tx_q[OCT_W-1];
                        tx_q   <= {tx_q[OCT_W-2:0], 1'b0};
                    end else begin
                        miso_q <= 1'b0;
                    end
                end
                if (oct_done) begin
                    unique case (st_q)
                        ST_HDR0: begin
                            file_q  <= byte_w[5:1];
                            dir_q   <= byte_w[7];
                            subhi_q <= byte_w[0];
                            if (!byte_w[6]) begin
                                if (byte_w[0]) begin
                                    cv_q <= 1'b1;
                                    cc_q <= byte_w[5:1];
                                end else begin
                                    sub_q <= '0;
                                    ld_q  <= ~byte_w[7];
                                end
                            end
                        end
                        ST_HDR1: begin
                            sub_q   <= {subhi_q, byte_w[7:2]};
                            idx_q   <= '0;
                            nmask_q <= (byte_w[1:0] == 2'b11) ? IDX_W'(MASK_OCT - 1)
                                                              : IDX_W'(byte_w[1:0] - 2'd1);
                            ld_q    <= ~dir_q;
                        end
                        ST_READ: begin
                            sub_q <= sub_q + 1'b1;
                            ld_q  <= 1'b1;
                        end
                        ST_WRITE: begin
                            we_q    <= 1'b1;
                            wdata_q <= byte_w;
                        end
                        ST_AND: begin
                            and_q[idx_q] <= byte_w;
                            idx_q <= (idx_q == nmask_q) ? '0 : idx_q + 1'b1;
                        end
                        ST_OR: begin
                            we_q    <= 1'b1;
                            wdata_q <= merged;
                            idx_q   <= idx_q + 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign spi_miso  = miso_q;
    assign reg_addr  = {file_q, sub_q};
    assign reg_wdata = wdata_q;
    assign reg_we    = we_q;
    assign cmd_code  = cc_q;
    assign cmd_valid = cv_q;

    // R2
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R2
    cmd_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (st_q == ST_SKIP));

    // R7
    commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ($past(sclk_rise) && !$past(csn_s)));

    // R6
    hdr_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HDR0) |-> !spi_miso);

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> ((st_q == ST_HDR0) && !reg_we));
endmodule

// File: tb/spi_regxact_decoder_tb.sv
`timescale 1ns/1ps
module spi_regxact_decoder_tb;
    localparam int HALF = 8;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic miso, reg_we, cmd_valid;
    logic [11:0] reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic [4:0]  cmd_code;

    logic [7:0] mem  [4096];
    logic [7:0] refm [4096];
    logic [7:0] txb  [20];
    logic [7:0] rxb  [20];
    int n_chk = 0, n_bad = 0;
    int fc_cnt = 0, wr_cnt = 0;
    logic [4:0] fc_last = '0;

    always #2.5 clk = ~clk;

    spi_regxact_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
        .spi_miso(miso), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .cmd_code(cmd_code), .cmd_valid(cmd_valid)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) ^ (i >> 4));
    endfunction

    assign reg_rdata = mem[reg_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) mem[i] <= pat(i);
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
        end
        if (rst_n && cmd_valid) begin fc_cnt <= fc_cnt + 1; fc_last <= cmd_code; end
        if (rst_n && reg_we) wr_cnt <= wr_cnt + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] hshort(input logic d, input logic [4:0] f);
        return {d, 1'b0, f, 1'b0};
    endfunction

    function automatic logic [15:0] hfull(input logic d, input logic [4:0] f,
                                          input logic [6:0] s, input logic [1:0] m);
        return {d, 1'b1, f, s[6], s[5:0], m};
    endfunction

    function automatic int aidx(input logic [4:0] f, input int s);
        return int'({f, 7'(s)});
    endfunction

    task automatic xfer(input int n, input int extra);
        @(negedge clk) csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b <= n; b++) begin
            for (int i = 7; i >= 0; i--) begin
                if (b == n && (7 - i) >= extra) break;
                mosi = txb[b][i];
                repeat (HALF) @(negedge clk);
                rxb[b][i] = miso;
                sclk = 1'b1;
                repeat (HALF) @(negedge clk);
                sclk = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic do_write(input bit shrt, input logic [4:0] f, input logic [6:0] s,
                            input int n, input string req);
        int h;
        logic [15:0] hf;
        if (shrt) begin txb[0] = hshort(1'b1, f); h = 1; s = '0; end
        else begin hf = hfull(1'b1, f, s, 2'b00); txb[0] = hf[15:8]; txb[1] = hf[7:0]; h = 2; end
        for (int k = 0; k < n; k++) begin
            txb[h+k] = 8'($urandom);
            refm[aidx(f, s + k)] = txb[h+k];
        end
        xfer(h + n, 0);
        for (int k = 0; k < n; k++) check(req, mem[aidx(f, s + k)], refm[aidx(f, s + k)]);
    endtask

    task automatic do_read(input bit shrt, input logic [4:0] f, input logic [6:0] s,
                           input logic [1:0] m, input int n, input string req);
        int h;
        logic [15:0] hf;
        if (shrt) begin txb[0] = hshort(1'b0, f); h = 1; s = '0; end
        else begin hf = hfull(1'b0, f, s, m); txb[0] = hf[15:8]; txb[1] = hf[7:0]; h = 2; end
        for (int k = 0; k < n; k++) txb[h+k] = 8'($urandom);
        xfer(h + n, 0);
        for (int k = 0; k < h; k++) check("R6 header miso", rxb[k], 8'h00);
        for (int k = 0; k < n; k++) check(req, rxb[h+k], refm[aidx(f, s + k)]);
        check("R6 idle miso", miso, 1'b0);
    endtask

    task automatic do_mask(input logic [4:0] f, input logic [6:0] s, input logic [1:0] m,
                           input int extra);
        int nb;
        logic [15:0] hf;
        logic [7:0] a;
        nb = (m == 2'b11) ? 4 : int'(m);
        hf = hfull(1'b1, f, s, m);
        txb[0] = hf[15:8]; txb[1] = hf[7:0];
        for (int k = 0; k < nb; k++) begin
            a = 8'($urandom);
            txb[2+k] = a;
            txb[2+nb+k] = 8'($urandom);
            refm[aidx(f, s + k)] = (refm[aidx(f, s + k)] & a) | txb[2+nb+k];
        end
        for (int k = 0; k < extra; k++) txb[2+2*nb+k] = 8'($urandom);
        xfer(2 + 2 * nb + extra, 0);
        for (int k = 0; k < nb + extra; k++)
            check("R8 masked update", mem[aidx(f, s + k)], refm[aidx(f, s + k)]);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c0, w0, kind;
        logic [4:0] f, code;
        logic [6:0] s;
        void'($urandom(32'd7));
        for (int i = 0; i < 4096; i++) refm[i] = pat(i);
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 miso", miso, 1'b0);
        check("R1 reg_we", reg_we, 1'b0);
        check("R1 cmd_valid", cmd_valid, 1'b0);

        // R2 fast command 0xA5
        c0 = fc_cnt; w0 = wr_cnt;
        txb[0] = 8'hA5; xfer(1, 0);
        check("R2 one pulse", fc_cnt - c0, 1);
        check("R2 code", fc_last, 5'h12);
        check("R2 no write", wr_cnt - w0, 0);
        for (int r = 0; r < 3; r++) begin
            code = 5'($urandom); c0 = fc_cnt;
            txb[0] = {1'b1, 1'b0, code, 1'b1}; xfer(1, 0);
            check("R2 random code", fc_last, code);
            check("R2 random pulse", fc_cnt - c0, 1);
        end

        // R4 worked header examples
        txb[0] = 8'h4A; txb[1] = 8'hB0; txb[2] = 0; txb[3] = 0; txb[4] = 0;
        xfer(5, 0);
        for (int k = 0; k < 3; k++) check("R4 read 4A B0", rxb[2+k], refm[aidx(5'h05, 8'h2C + k)]);
        do_write(1'b0, 5'h05, 7'h10, 3, "R4 write CA 40");
        check("R4 header byte0", txb[0], 8'hCA);
        check("R4 header byte1", txb[1], 8'h40);

        // R3 short write, then short read
        do_write(1'b1, 5'h0B, 7'h00, 3, "R3 short write");
        do_read(1'b1, 5'h0B, 7'h00, 2'b00, 4, "R3 short read");

        // R5 wrap within the file
        do_write(1'b0, 5'h1E, 7'h7F, 2, "R5 wrap write");
        do_read(1'b0, 5'h1E, 7'h7E, 2'b00, 3, "R5 wrap read");

        // R8 masked modes with trailing octets
        do_mask(5'h03, 7'h20, 2'b01, 2);
        do_mask(5'h03, 7'h40, 2'b10, 2);
        do_mask(5'h03, 7'h7E, 2'b11, 1);

        // R9 mode bits on a read are ignored
        w0 = wr_cnt;
        do_read(1'b0, 5'h03, 7'h20, 2'b11, 3, "R9 read mode ignored");
        check("R9 no write", wr_cnt - w0, 0);

        // R7 partial octet dropped at abort
        w0 = wr_cnt;
        txb[0] = hshort(1'b1, 5'h09); txb[1] = 8'h5C; txb[2] = 8'hFF;
        refm[aidx(5'h09, 0)] = 8'h5C;
        xfer(2, 5);
        check("R7 full octet written", mem[aidx(5'h09, 0)], 8'h5C);
        check("R7 partial dropped", mem[aidx(5'h09, 1)], refm[aidx(5'h09, 1)]);
        check("R7 one pulse", wr_cnt - w0, 1);

        // R10 abort inside a two-octet header, then fast command decodes afresh
        txb[0] = 8'hC4; txb[1] = 8'hFF;
        xfer(1, 3);
        c0 = fc_cnt;
        txb[0] = {1'b1, 1'b0, 5'h07, 1'b1}; xfer(1, 0);
        check("R10 fresh header code", fc_last, 5'h07);
        check("R10 fresh header pulse", fc_cnt - c0, 1);

        // mixed random traffic
        for (int r = 0; r < 24; r++) begin
            kind = int'($urandom_range(0, 4));
            f = 5'($urandom); s = 7'($urandom);
            case (kind)
                0: do_write(1'b1, f, s, int'($urandom_range(1, 3)), "R3 random short write");
                1: do_read(1'b1, f, s, 2'b00, 3, "R3 random short read");
                2: do_write(1'b0, f, s, int'($urandom_range(1, 3)), "R5 random full write");
                3: do_read(1'b0, f, s, 2'b00, 3, "R5 random full read");
                default: do_mask(f, s, 2'($urandom_range(1, 3)), 1);
            endcase
        end

        w0 = 0;
        for (int i = 0; i < 4096; i++) if (mem[i] !== refm[i]) w0++;
        check("R5 final storage", w0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule